// File: doc/BRIEF.md
# Sequentially Consistent Memory Issue Gate

This block sits between one processor's in-order request queue and a directory-based coherence fabric. It takes one memory operation at a time from the processor, sends it into the fabric, and does not take the next one until the current operation is visible to every processor. An operation is not finished when its data reply arrives. It is finished when every invalidation that the fabric sent for it has been acknowledged and, for a read, when the write that produced the returned value has itself completed.

The fabric reports three kinds of event, and they can arrive in any order. The reply carries the data, the number of acknowledgements to expect, and a flag that says the source write is still in flight. Invalidation acknowledgements arrive as single-cycle pulses. A separate pulse reports that the source write has completed. Acknowledgements may arrive before the reply that announces how many to expect, so the gate keeps a signed balance of expected minus received acknowledgements. When the balance is zero and no source write is pending, the gate reports completion with a one-cycle pulse and then accepts the next request.

Top module: `sc_issue_gate`

## Requirements
- R1: The downstream request carries exactly the type, address and write data of the request the gate accepted. Requests leave in the order they were accepted.
- R2: `req_ready_o` is high only while no operation is held. It drops in the cycle after an acceptance and returns in the cycle after the completion pulse.
- R3: The gate raises `mem_valid_o` in the cycle after it accepts a request. It holds `mem_valid_o` and its payload stable until `mem_ready_i` is seen, and then drops it.
- R4: Between the downstream handshake and the completion pulse, neither `mem_valid_o` nor `req_ready_o` is asserted, whatever mix of replies and acknowledgements is outstanding.
- R5: `done_o` pulses for exactly one cycle, two clock edges after the input that settles the operation. That input is the reply, the last acknowledgement, or the source-write notification, whichever comes last. `done_o` stays low until then.
- R6: Acknowledgements that arrive before the reply are credited against the count the reply later carries. A write whose acknowledgements all come early completes as soon as the reply arrives.
- R7: A read whose reply has `rsp_src_pend_i` = 1 does not complete until `wr_gp_i` has pulsed. That pulse may come before, with, or after the reply. On a write's reply, `rsp_src_pend_i` is ignored.
- R8: During the completion pulse of a read, `rd_data_o` equals the reply data. At all other times it is zero. `done_is_write_o` is 1 during a write's completion pulse and 0 during a read's.
- R9: While `rst_ni` is low, the gate shows `req_ready_o` = 1, `mem_valid_o` = 0 and `done_o` = 0.
- R10: A reply with an invalidation count of zero and no pending source completes with no acknowledgement at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request valid |
| req_ready_o | output | 1 | Gate can accept a request |
| req_is_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | DW | Write data |
| mem_valid_o | output | 1 | Downstream request valid |
| mem_ready_i | input | 1 | Fabric accepts the downstream request |
| mem_is_write_o | output | 1 | Downstream operation type |
| mem_addr_o | output | AW | Downstream address |
| mem_wdata_o | output | DW | Downstream write data |
| rsp_valid_i | input | 1 | Data reply valid, one per operation |
| rsp_data_i | input | DW | Reply data |
| rsp_inv_cnt_i | input | CW | Number of acknowledgements to expect |
| rsp_src_pend_i | input | 1 | Source write not yet globally performed |
| inv_ack_i | input | 1 | One invalidation acknowledgement |
| wr_gp_i | input | 1 | Source write globally performed |
| done_o | output | 1 | Completion pulse |
| done_is_write_o | output | 1 | Completed operation was a write |
| rd_data_o | output | DW | Read data during completion |

## Verification
The assertions assume a well-behaved fabric. It sends exactly one reply per operation and only after the downstream handshake. It never sends more acknowledgements than the reply announces. It sends acknowledgements and source-write pulses only while an operation is outstanding. The stimulus generator respects these limits. It splits each operation's acknowledgements into an early group and a late group. It can place one late acknowledgement in the same cycle as the reply. It places the source-write pulse on either side of the reply. It inserts random idle gaps, but it never lets the total acknowledgements exceed the announced count.

// File: rtl/sc_gate_pkg.sv
package sc_gate_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT_REPLY,
    ST_WAIT_ACKS,
    ST_DONE
  } gate_state_e;
endpackage

// File: rtl/sc_gate_fsm.sv
module sc_gate_fsm
  import sc_gate_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_fire_i,
  input  logic        mem_fire_i,
  input  logic        rsp_valid_i,
  input  logic        settled_i,
  output gate_state_e state_o
);
  gate_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (req_fire_i)  state_d = ST_ISSUE;
      ST_ISSUE:      if (mem_fire_i)  state_d = ST_WAIT_REPLY;
      ST_WAIT_REPLY: if (rsp_valid_i) state_d = ST_WAIT_ACKS;
      ST_WAIT_ACKS:  if (settled_i)   state_d = ST_DONE;
      ST_DONE:                        state_d = ST_IDLE;
      default:                        state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/sc_gate_ack_tracker.sv
module sc_gate_ack_tracker #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          track_en_i,
  input  logic          rsp_take_i,
  input  logic [CW-1:0] rsp_cnt_i,
  input  logic          rsp_pend_i,
  input  logic          ack_i,
  input  logic          gp_i,
  output logic signed [CW:0] bal_o,
  output logic          settled_o
);
  localparam int BW = CW + 1;
  localparam logic signed [BW-1:0] BAL_ONE = BW'(1);

  logic signed [BW-1:0] bal_q, bal_d, add_v, sub_v;
  logic pend_q, gp_q;
  logic ack_take;

  assign ack_take = ack_i & track_en_i;

  always_comb begin
    add_v = rsp_take_i ? $signed({1'b0, rsp_cnt_i}) : '0;
    sub_v = ack_take ? BAL_ONE : '0;
    bal_d = bal_q + add_v - sub_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bal_q  <= '0;
      pend_q <= 1'b0;
      gp_q   <= 1'b0;
    end else if (clear_i) begin
      bal_q  <= '0;
      pend_q <= 1'b0;
      gp_q   <= 1'b0;
    end else begin
      bal_q <= bal_d;
      if (rsp_take_i && rsp_pend_i) pend_q <= 1'b1;
      if (gp_i && track_en_i)       gp_q   <= 1'b1;
    end
  end

  // a source notification may precede the reply that asks for it
  assign settled_o = (bal_q == '0) && !(pend_q && !gp_q);
  assign bal_o     = bal_q;
endmodule

// File: rtl/sc_gate_op_reg.sv
module sc_gate_op_reg #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          is_write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rsp_take_i,
  input  logic [DW-1:0] rsp_data_i,
  output logic          is_write_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      is_write_o <= 1'b0;
      addr_o     <= '0;
      wdata_o    <= '0;
      rdata_o    <= '0;
    end else begin
      if (load_i) begin
        is_write_o <= is_write_i;
        addr_o     <= addr_i;
        wdata_o    <= wdata_i;
        rdata_o    <= '0;
      end
      if (rsp_take_i && !is_write_o) rdata_o <= rsp_data_i;
    end
  end
endmodule

// File: rtl/sc_issue_gate.sv
module sc_issue_gate
  import sc_gate_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_is_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          mem_valid_o,
  input  logic          mem_ready_i,
  output logic          mem_is_write_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i,
  input  logic [CW-1:0] rsp_inv_cnt_i,
  input  logic          rsp_src_pend_i,
  input  logic          inv_ack_i,
  input  logic          wr_gp_i,
  output logic          done_o,
  output logic          done_is_write_o,
  output logic [DW-1:0] rd_data_o
);
  gate_state_e state;
  logic req_fire, mem_fire, rsp_take, track_en, settled, op_wr;
  logic signed [CW:0] ack_bal;
  logic [DW-1:0] rdata_q;

  assign req_ready_o = (state == ST_IDLE);
  assign req_fire    = req_valid_i & req_ready_o;
  assign mem_valid_o = (state == ST_ISSUE);
  assign mem_fire    = mem_valid_o & mem_ready_i;
  assign rsp_take    = rsp_valid_i & (state == ST_WAIT_REPLY);
  assign track_en    = (state == ST_WAIT_REPLY) | (state == ST_WAIT_ACKS);

  sc_gate_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_fire_i  (req_fire),
    .mem_fire_i  (mem_fire),
    .rsp_valid_i (rsp_take),
    .settled_i   (settled),
    .state_o     (state)
  );

  sc_gate_op_reg #(.AW(AW), .DW(DW)) u_op (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (req_fire),
    .is_write_i (req_is_write_i),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .rsp_take_i (rsp_take),
    .rsp_data_i (rsp_data_i),
    .is_write_o (op_wr),
    .addr_o     (mem_addr_o),
    .wdata_o    (mem_wdata_o),
    .rdata_o    (rdata_q)
  );

  // only a read can depend on a write that is still propagating
  sc_gate_ack_tracker #(.CW(CW)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (req_fire),
    .track_en_i (track_en),
    .rsp_take_i (rsp_take),
    .rsp_cnt_i  (rsp_inv_cnt_i),
    .rsp_pend_i (rsp_src_pend_i & ~op_wr),
    .ack_i      (inv_ack_i),
    .gp_i       (wr_gp_i),
    .bal_o      (ack_bal),
    .settled_o  (settled)
  );

  assign mem_is_write_o  = op_wr;
  assign done_o          = (state == ST_DONE);
  assign done_is_write_o = done_o & op_wr;
  assign rd_data_o       = (done_o && !op_wr) ? rdata_q : '0;
endmodule

// File: rtl/sc_issue_gate_chk.sv
module sc_issue_gate_chk #(
  parameter int AW = 16,
  parameter int CW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          mem_valid_o,
  input logic          mem_ready_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          done_o,
  input logic signed [CW:0] ack_bal_i,
  input logic          settled_i
);
  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o && mem_valid_o);

  p_hold_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o));

  p_single_issue_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_ready_i |=> !mem_valid_o);

  p_no_issue_outstanding_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_bal_i != '0) |-> !mem_valid_o && !req_ready_o);

  p_done_after_settle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(settled_i));

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o);

  p_reset_idle_r9: assert property (@(posedge clk_i)
    !rst_ni |-> req_ready_o && !mem_valid_o && !done_o);
endmodule

bind sc_issue_gate sc_issue_gate_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .done_o      (done_o),
  .ack_bal_i   (ack_bal),
  .settled_i   (settled)
);

// File: tb/sc_issue_gate_bench.sv
module sc_issue_gate_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0, req_is_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, mem_valid, mem_is_write;
  logic mem_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic rsp_valid = 1'b0, rsp_src_pend = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic [CW-1:0] rsp_inv_cnt = '0;
  logic inv_ack = 1'b0, wr_gp = 1'b0;
  logic done, done_is_write;
  logic [DW-1:0] rd_data;

  int checks = 0, failures = 0;
  bit busy = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sc_issue_gate #(.AW(AW), .DW(DW), .CW(CW)) u_sc_issue_gate (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_is_write_i(req_is_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_is_write_o(mem_is_write),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data), .rsp_inv_cnt_i(rsp_inv_cnt),
    .rsp_src_pend_i(rsp_src_pend), .inv_ack_i(inv_ack), .wr_gp_i(wr_gp),
    .done_o(done), .done_is_write_o(done_is_write), .rd_data_o(rd_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock model check: nothing new may leave while an operation is open
  always @(negedge clk) begin
    if (busy && rst_ni) begin
      chk(!mem_valid && !req_ready, "R4 gate closed while outstanding",
          longint'({mem_valid, req_ready}), 0);
      chk(!done || finished, "R5 no early completion", longint'(done), 0);
    end
  end

  task automatic step(input bit ack, input bit rsp, input bit gp);
    inv_ack = ack; rsp_valid = rsp; wr_gp = gp;
    @(negedge clk);
    inv_ack = 1'b0; rsp_valid = 1'b0; wr_gp = 1'b0;
  endtask

  task automatic gaps();
    int n = $urandom_range(0, 2);
    for (int g = 0; g < n; g++) step(0, 0, 0);
  endtask

  task automatic run_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int ninv, input int pre, input bit pend_pin,
                        input bit gp_early, input bit join_ack, input logic [DW-1:0] rv);
    int guard = 0;
    int post;
    int hold;
    bit pend_eff = pend_pin && !wr;
    while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
    chk(req_ready, "R2 ready when idle", longint'(req_ready), 1);
    req_valid = 1'b1; req_is_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 ready drops after accept", longint'(req_ready), 0);
    chk(mem_valid, "R3 issue follows accept", longint'(mem_valid), 1);
    chk(mem_addr == a && mem_is_write == wr && (!wr || mem_wdata == d),
        "R1 downstream payload", longint'(mem_addr), longint'(a));
    hold = $urandom_range(0, 3);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(mem_valid && mem_addr == a, "R3 request held", longint'(mem_valid), 1);
    end
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    busy = 1'b1;
    chk(!mem_valid, "R3 request drops after handshake", longint'(mem_valid), 0);
    rsp_data = rv; rsp_inv_cnt = CW'(ninv); rsp_src_pend = pend_pin;
    for (int i = 0; i < pre; i++) begin gaps(); step(1, 0, 0); end
    if (pend_eff && gp_early) begin gaps(); step(0, 0, 1); end
    post = ninv - pre;
    gaps();
    if (join_ack && post > 0) begin step(1, 1, 0); post--; end
    else step(0, 1, 0);
    for (int i = 0; i < post; i++) begin gaps(); step(1, 0, 0); end
    if (pend_eff && !gp_early) begin gaps(); step(0, 0, 1); end
    // settling input was sampled at the edge before this negedge
    chk(!done, "R5 not yet done one edge after settle", longint'(done), 0);
    finished = 1'b1;
    @(negedge clk);
    chk(done, "R5 done two edges after settle", longint'(done), 1);
    chk(done_is_write == wr, "R8 completion type", longint'(done_is_write), longint'(wr));
    chk(rd_data == (wr ? '0 : rv), "R8 read data on completion",
        longint'(rd_data), longint'(wr ? '0 : rv));
    busy = 1'b0; finished = 1'b0;
    @(negedge clk);
    chk(!done && req_ready, "R2 ready after completion pulse", longint'({done, req_ready}), 1);
    chk(rd_data == '0, "R8 data zero outside completion", longint'(rd_data), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_valid && !done, "R9 reset outputs",
        longint'({req_ready, mem_valid, done}), 4);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10: no acknowledgements expected
    run_op(0, 16'h0010, 32'h0, 0, 0, 0, 0, 0, 32'hA5A5_0001);
    // R6: all acks after the reply, then all before it (negative balance)
    run_op(1, 16'h0020, 32'h1111_2222, 3, 0, 0, 0, 0, 32'h0);
    run_op(1, 16'h0030, 32'h3333_4444, 3, 3, 0, 0, 0, 32'h0);
    // R7: pending source, notification late and early
    run_op(0, 16'h0040, 32'h0, 2, 1, 1, 0, 0, 32'hBEEF_0040);
    run_op(0, 16'h0050, 32'h0, 0, 0, 1, 1, 0, 32'hBEEF_0050);
    // R7: pending flag on a write reply must be ignored
    run_op(1, 16'h0060, 32'h5555_6666, 1, 0, 1, 0, 0, 32'h0);
    // R6: largest count, split, one ack together with the reply
    run_op(1, 16'h0070, 32'h7777_8888, 15, 7, 0, 0, 1, 32'h0);
    for (int k = 0; k < 40; k++) begin
      int n = $urandom_range(0, 6);
      run_op(1'($urandom_range(0, 1)), AW'($urandom), $urandom, n,
             $urandom_range(0, n), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule